// File: doc/BRIEF.md
# HDLC Synchronous Frame Receiver

This block takes a synchronous serial line that carries bit-oriented frames and turns it into a byte stream. The line is sampled once whenever `bit_en` is high. Each sample is first converted from transition coding: a change of level gives a 0 and an unchanged level gives a 1. A single counter of consecutive ones then classifies each bit. The bit can be ordinary data, an inserted zero that must be dropped, the end of a flag (six ones followed by a zero), or an abort (seven ones). Data bits are packed into bytes with the earliest bit in bit 0.

Each frame comes out as a run of byte beats. The first beat is tagged start-of-frame and the last is tagged end-of-frame. The end-of-frame beat also carries a status code. The two check bytes at the end of a frame are verified with the reflected 16-bit CCITT polynomial and are never delivered. Frame content is released with three bytes of lag, so the check bytes can be held back without buffering a whole frame. Consecutive frames may share one flag, and two flags may even share a single zero.

Top module: `hdlc_sync_rx_deframer`

## Requirements
- R1: A sampled line level equal to the previous sampled level decodes as bit 1, and a level change decodes as bit 0. The line is only sampled in cycles where `bit_en` is high, and the previous level is 1 after reset.
- R2: A decoded 0 that follows exactly five decoded 1s is discarded and does not enter the frame data.
- R3: A 0 that follows exactly six 1s is a flag. It closes any frame in progress and starts a new one. A frame with no data bits between two flags produces no beats, and neither do idle ones after a flag.
- R4: The final 0 of one flag may serve as the first 0 of the next flag (pattern 0111111011111101111110). Frames around such a pair are received normally.
- R5: Seven consecutive 1s are an abort. If any data bits of the current frame had been released into the byte assembler, a single end beat is emitted with data 0x00 and status 2. The receiver then ignores everything until the next flag.
- R6: Bytes are assembled least significant bit first: the first data bit after a flag lands in bit 0 of the first byte.
- R7: The CRC register is preset to 0xFFFF and runs over all frame bytes, including the two check bytes. On a length-valid frame, the end beat carries the last byte before the check bytes, with status 0 when the final register value is 0xF0B8 and status 1 otherwise. The two check bytes are never output.
- R8: A frame whose bit count between flags is not a multiple of 8, or that holds fewer than 4 bytes, ends with a beat of data 0x00 and status 3.
- R9: In a frame of C whole bytes, bytes 0 to C-4 are output in order as they become known, with `out_sof` on the first beat of the frame. `out_eof` is set only on the closing beat, and `out_status` is 0 on every beat that is not the closing beat.
- R10: After reset `out_valid` is low, and the receiver discards all bits until it has seen the first flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Sample `line_in` in this cycle |
| line_in | input | 1 | Transition-coded serial line |
| out_valid | output | 1 | A byte beat is presented this cycle |
| out_data | output | 8 | Byte value of the beat |
| out_sof | output | 1 | Beat is the first of a frame |
| out_eof | output | 1 | Beat is the last of a frame |
| out_status | output | 2 | On the end beat: 0 good, 1 check error, 2 abort, 3 length error |

## Verification
The one flag event does two jobs in the same cycle. It produces the end beat of the frame that is closing, and it rearms the delay line, byte counter, release flag and CRC for the frame that follows. The bench provokes this in three ways: frames separated by a single flag, two flags sharing one zero, and a flag directly followed by new data. It judges the result by requiring the next frame's first beat to carry start-of-frame and correct data, with no stray beat between frames. Data release and frame close cannot fall together, because a flag bit is never a data bit. The bench therefore also checks that the last released byte and the end beat arrive as separate beats.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    ST_GOOD   = 2'd0,
    ST_BADFCS = 2'd1,
    ST_ABORT  = 2'd2,
    ST_LENGTH = 2'd3
  } rx_status_e;

  localparam int STUFF_RUN = 5;
  localparam int FLAG_RUN  = 6;
  localparam int FCS_W     = 16;

  function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c,
                                                input logic b,
                                                input logic [FCS_W-1:0] poly);
    logic fb;
    fb = c[0] ^ b;
    crc_step = (c >> 1) ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/hdlc_bit_decoder.sv
module hdlc_bit_decoder
  import hdlc_rx_pkg::*;
#(
  parameter int RUN_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic line_in,
  output logic push_o,
  output logic bit_o,
  output logic flag_o,
  output logic abort_o
);
  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(FLAG_RUN);
  localparam logic [RUN_W-1:0] RUN_SAT   = '1;

  logic             prev_q;
  logic [RUN_W-1:0] run_q;
  logic             one_bit;

  assign one_bit = (line_in == prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;
      run_q   <= '0;
      push_o  <= 1'b0;
      bit_o   <= 1'b0;
      flag_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      push_o  <= 1'b0;
      flag_o  <= 1'b0;
      abort_o <= 1'b0;
      if (bit_en) begin
        prev_q <= line_in;
        bit_o  <= one_bit;
        if (one_bit) begin
          if (run_q < RUN_STUFF) push_o <= 1'b1;
          if (run_q == RUN_FLAG) abort_o <= 1'b1;
          if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
        end else begin
          if (run_q < RUN_STUFF) push_o <= 1'b1;
          if (run_q == RUN_FLAG) flag_o <= 1'b1;
          run_q <= '0;
        end
      end
    end
  end

  // R1
  push_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    push_o |-> $past(bit_en));

  // R3
  flag_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    flag_o |-> !$past(flag_o));

endmodule

// File: rtl/hdlc_fcs_check.sv
module hdlc_fcs_check
  import hdlc_rx_pkg::*;
#(
  parameter logic [FCS_W-1:0] POLY    = 16'h8408,
  parameter logic [FCS_W-1:0] RESIDUE = 16'hF0B8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  input  logic bit_i,
  output logic match_o
);
  logic [FCS_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= '1;
    else if (en)      crc_q <= crc_step(crc_q, bit_i, POLY);
  end

  assign match_o = (crc_q == RESIDUE);

endmodule

// File: rtl/hdlc_byte_framer.sv
module hdlc_byte_framer
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int DLY       = 6,
  parameter int HOLD      = 3,
  parameter int MIN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              bit_i,
  input  logic              flag_i,
  input  logic              abort_i,
  input  logic              fcs_ok_i,
  output logic              crc_clr_o,
  output logic              crc_en_o,
  output logic              crc_bit_o,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic [1:0]        out_status
);
  localparam int BCNT_W = $clog2(BYTE_W);
  localparam int FILL_W = $clog2(DLY + 1);
  localparam int NB_W   = $clog2(MIN_BYTES + 1);
  localparam int HC_W   = $clog2(HOLD + 1);
  localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(BYTE_W - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DLY);
  localparam logic [NB_W-1:0]   NB_MIN    = NB_W'(MIN_BYTES);
  localparam logic [HC_W-1:0]   HC_FULL   = HC_W'(HOLD);

  logic              active_q, seen_q, sent_q;
  logic [DLY-1:0]    dly_q;
  logic [FILL_W-1:0] fill_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic [NB_W-1:0]   nb_q;
  logic [HC_W-1:0]   hcnt_q;
  logic [BYTE_W-1:0] hold_q [HOLD];

  logic              exit_v;
  logic [BYTE_W-1:0] new_byte;

  assign exit_v    = active_q && push_i && (fill_q == FILL_FULL) && !flag_i && !abort_i;
  assign new_byte  = {dly_q[0], sr_q[BYTE_W-1:1]};
  assign crc_clr_o = flag_i || abort_i;
  assign crc_en_o  = exit_v;
  assign crc_bit_o = dly_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0; seen_q <= 1'b0; sent_q <= 1'b0;
      dly_q <= '0; fill_q <= '0; bcnt_q <= '0; sr_q <= '0;
      nb_q <= '0; hcnt_q <= '0;
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0;
      out_eof <= 1'b0; out_status <= ST_GOOD;
    end else begin
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0;
      out_eof <= 1'b0; out_status <= ST_GOOD;
      if (flag_i || abort_i) begin
        if (active_q && seen_q) begin
          out_valid <= 1'b1;
          out_eof   <= 1'b1;
          out_sof   <= !sent_q;
          if (abort_i)
            out_status <= ST_ABORT;
          else if (bcnt_q != '0 || nb_q < NB_MIN)
            out_status <= ST_LENGTH;
          else begin
            out_data   <= hold_q[HOLD-1];
            out_status <= fcs_ok_i ? ST_GOOD : ST_BADFCS;
          end
        end
        active_q <= flag_i;
        seen_q <= 1'b0; sent_q <= 1'b0;
        fill_q <= '0; bcnt_q <= '0; nb_q <= '0; hcnt_q <= '0;
      end else if (active_q && push_i) begin
        dly_q <= {bit_i, dly_q[DLY-1:1]};
        if (fill_q != FILL_FULL) begin
          fill_q <= fill_q + 1'b1;
        end else begin
          seen_q <= 1'b1;
          sr_q   <= new_byte;
          bcnt_q <= (bcnt_q == BCNT_LAST) ? '0 : bcnt_q + 1'b1;
          if (bcnt_q == BCNT_LAST) begin
            if (nb_q != NB_MIN) nb_q <= nb_q + 1'b1;
            hold_q[0] <= new_byte;
            for (int i = 1; i < HOLD; i++) hold_q[i] <= hold_q[i-1];
            if (hcnt_q == HC_FULL) begin
              out_valid <= 1'b1;
              out_data  <= hold_q[HOLD-1];
              out_sof   <= !sent_q;
              sent_q    <= 1'b1;
            end else begin
              hcnt_q <= hcnt_q + 1'b1;
            end
          end
        end
      end
    end
  end

  logic open_q;
  always_ff @(posedge clk) begin
    if (rst)            open_q <= 1'b0;
    else if (out_valid) open_q <= !out_eof;
  end

  // R9
  sof_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> !open_q);

  // R9
  continue_when_open_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> open_q);

  // R3
  beat_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(push_i || flag_i || abort_i));

  // R5
  abort_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == ST_ABORT) |-> ($past(abort_i) && out_data == '0));

endmodule

// File: rtl/hdlc_sync_rx_deframer.sv
module hdlc_sync_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int RUN_W     = 3,
  parameter int MIN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              line_in,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic [1:0]        out_status
);
  localparam int DLY  = FLAG_RUN;
  localparam int HOLD = FCS_W / BYTE_W + 1;

  logic push, dbit, flag, abort_ev;
  logic crc_clr, crc_en, crc_bit, fcs_ok;

  hdlc_bit_decoder #(.RUN_W(RUN_W)) u_dec (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_in(line_in),
    .push_o(push), .bit_o(dbit), .flag_o(flag), .abort_o(abort_ev)
  );

  hdlc_fcs_check u_fcs (
    .clk(clk), .rst(rst), .clear(crc_clr), .en(crc_en),
    .bit_i(crc_bit), .match_o(fcs_ok)
  );

  hdlc_byte_framer #(
    .BYTE_W(BYTE_W), .DLY(DLY), .HOLD(HOLD), .MIN_BYTES(MIN_BYTES)
  ) u_frm (
    .clk(clk), .rst(rst), .push_i(push), .bit_i(dbit), .flag_i(flag),
    .abort_i(abort_ev), .fcs_ok_i(fcs_ok), .crc_clr_o(crc_clr),
    .crc_en_o(crc_en), .crc_bit_o(crc_bit), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_status(out_status)
  );

endmodule

// File: tb/tb_hdlc_sync_rx_deframer.sv
module tb_hdlc_sync_rx_deframer;
  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, line_in = 1'b1;
  logic       out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic [1:0] out_status;

  hdlc_sync_rx_deframer dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_in(line_in),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_status(out_status)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];
  string tag_q[$];
  bit pl[$];
  int tx_run = 0;
  logic line_lvl = 1'b1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input bit b);
    @(negedge clk);
    if (!b) line_lvl = ~line_lvl;
    line_in = line_lvl;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_flag();
    tick(1'b0);
    repeat (6) tick(1'b1);
    tick(1'b0);
    tx_run = 0;
  endtask

  task automatic send_stuffed(input bit b);
    tick(b);
    if (b) begin
      tx_run++;
      if (tx_run == 5) begin
        tick(1'b0);
        tx_run = 0;
      end
    end else tx_run = 0;
  endtask

  task automatic raw_byte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) tick(v[k]);
  endtask

  task automatic add_byte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) pl.push_back(v[k]);
  endtask

  function automatic logic [15:0] crc_of(input bit q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i]) begin
      bit fb = c[0] ^ q[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic add_fcs(input bit corrupt);
    logic [15:0] f;
    f = ~crc_of(pl);
    if (corrupt) f = f ^ 16'h0001;
    for (int k = 0; k < 16; k++) pl.push_back(f[k]);
  endtask

  // Reference: bits released into the byte assembler for one frame -> beats
  task automatic expect_frame(input bit q[$], input bit aborted, input string tag);
    int e, c, em;
    logic [7:0] b;
    logic [15:0] r;
    e = q.size();
    if (e == 0) return;
    c = e / 8;
    em = (c > 3) ? c - 3 : 0;
    for (int i = 0; i < em; i++) begin
      for (int k = 0; k < 8; k++) b[k] = q[8*i+k];
      exp_q.push_back({b, (i == 0), 1'b0, 2'd0});
      tag_q.push_back(tag);
    end
    if (!aborted && (e % 8 == 0) && c >= 4) begin
      r = crc_of(q);
      for (int k = 0; k < 8; k++) b[k] = q[8*(c-3)+k];
      exp_q.push_back({b, (em == 0), 1'b1, (r == 16'hF0B8) ? 2'd0 : 2'd1});
    end else begin
      exp_q.push_back({8'h00, (em == 0), 1'b1, aborted ? 2'd2 : 2'd3});
    end
    tag_q.push_back(tag);
  endtask

  task automatic end_with_flag(input string tag);
    expect_frame(pl, 1'b0, tag);
    foreach (pl[i]) send_stuffed(pl[i]);
    send_flag();
    pl.delete();
  endtask

  task automatic end_with_abort(input string tag);
    bit m[$];
    int r;
    r = 0;
    m = pl;
    foreach (pl[i]) begin
      if (pl[i]) begin
        r++;
        if (r == 5) r = 0;
      end else r = 0;
    end
    for (int k = r; k < 5; k++) m.push_back(1'b1);
    if (m.size() > 6) begin
      repeat (6) void'(m.pop_back());
    end else m.delete();
    expect_frame(m, 1'b1, tag);
    foreach (pl[i]) send_stuffed(pl[i]);
    repeat (7) tick(1'b1);
    pl.delete();
  endtask

  always @(negedge clk) begin
    logic [11:0] got;
    string t;
    if (!rst && out_valid) begin
      got = {out_data, out_sof, out_eof, out_status};
      if (exp_q.size() == 0) check(1'b0, "R3", "unexpected beat", {20'd0, got}, 0);
      else begin
        t = tag_q.pop_front();
        check(got == exp_q[0], t, "beat {data,sof,eof,status}", {20'd0, got}, {20'd0, exp_q[0]});
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "valid after reset", {31'd0, out_valid}, 0);

    // R10: bits before the first flag are ignored
    repeat (12) tick(1'b1);
    raw_byte(8'hA5);
    raw_byte(8'h4C);
    send_flag();

    // R1 R2 R6 R7 R9: stuffing-heavy good frame
    add_byte(8'h03); add_byte(8'hFF); add_byte(8'h7E); add_byte(8'h3E); add_byte(8'hF8);
    add_fcs(1'b0);
    end_with_flag("R1/R2/R6/R7/R9");

    // R7: minimum good frame, opened by the previous closing flag
    add_byte(8'hC1); add_byte(8'h2D);
    add_fcs(1'b0);
    end_with_flag("R7");

    // R7: corrupted check bytes
    add_byte(8'h10); add_byte(8'h20); add_byte(8'h30); add_byte(8'h40);
    add_fcs(1'b1);
    end_with_flag("R7");

    // R3: back-to-back flags, then R4: flag sharing one zero
    send_flag();
    repeat (6) tick(1'b1);
    tick(1'b0);
    add_byte(8'h81); add_byte(8'h5A); add_byte(8'hE7);
    add_fcs(1'b0);
    end_with_flag("R4");

    // R8: non-octet length
    add_byte(8'h11); add_byte(8'h22); add_byte(8'h33); add_byte(8'h44); add_byte(8'h56);
    pl.push_back(1'b1); pl.push_back(1'b0); pl.push_back(1'b1);
    end_with_flag("R8");

    // R8: too short (3 bytes including check bytes)
    add_byte(8'h55);
    add_fcs(1'b0);
    end_with_flag("R8");

    // R3: idle ones after a flag give nothing; R5: abort mid-frame
    repeat (10) tick(1'b1);
    send_flag();
    for (int i = 0; i < 6; i++) add_byte(8'(i * 16));
    end_with_abort("R5");
    repeat (10) tick(1'b1);
    raw_byte(8'h12);
    raw_byte(8'h24);
    send_flag();
    add_byte(8'h9C); add_byte(8'h01); add_byte(8'hFE);
    add_fcs(1'b0);
    end_with_flag("R5");

    // R5: abort shortly after opening
    add_byte(8'h00);
    end_with_abort("R5");
    send_flag();

    // R6 R9: longer frame
    for (int i = 0; i < 8; i++) add_byte(8'(8'h3B + i * 37));
    add_fcs(1'b0);
    end_with_flag("R6/R9");

    repeat (20) tick(1'b1);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R3", "pending beats", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule